// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This unit decides whether a fixed-point conditional trap instruction fires. It takes two 64-bit operands and compares them five ways at once: unsigned greater, unsigned less, equal, signed greater and signed less. A 5-bit condition mask picks which of these relations may fire the trap. A separate 5-bit forced-type vector fires the trap whatever the operands are when any of its bits is set. The five raw relation bits are also brought out so that later logic can use them.

A narrow-mode flag limits the comparison to the low 32-bit words. The signed relations then see each low word sign-extended. The unsigned and equality relations see each low word with zero upper bits. The unit is purely combinational inside. A parameter adds one output register stage, with an active-low asynchronous reset, for timing closure. When `REGISTERED` is 0, the clock and reset have no effect.

The block has no state machine. Its only sequential element is the optional output register, which has two conditions: cleared under reset, and loading new results on every clock.

Top module: `trapcmp_unit`

## Requirements
- R1: `cond_bits` holds the relations at fixed positions: bit 0 unsigned a>b, bit 1 unsigned a<b, bit 2 a==b, bit 3 signed a>b, bit 4 signed a<b.
- R2: `trap_fire` is 1 whenever any bit of `force_type` is 1, for any operands and any mask.
- R3: With `force_type` zero, `trap_fire` equals the OR over i of `cond_bits[i] & cond_mask[i]`.
- R4: With `cond_mask` zero and `force_type` zero, `trap_fire` is 0 for all operands.
- R5: With `narrow_mode`=1, each signed relation (bits 3 and 4) compares the low 32 bits of each operand sign-extended to 64 bits.
- R6: With `narrow_mode`=1, the unsigned and equality relations (bits 0 to 2) compare the low 32 bits with the upper bits taken as zero. Operand bits 63..32 have no effect on any output.
- R7: With `narrow_mode`=0, all five relations use the full 64-bit operands.
- R8: In each domain exactly one relation holds. Exactly one of bits {0,1,2} is 1, and exactly one of bits {2,3,4} is 1.
- R9: With `REGISTERED`=1, the outputs show the result for the inputs present at the previous rising clock edge. While `rst_n` is 0, both outputs are 0.
- R10: With `REGISTERED`=0, the outputs follow the inputs in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cond_mask | input | 5 | Enables for the relations, one bit per `cond_bits` position |
| narrow_mode | input | 1 | 1 = compare 32-bit low words, 0 = full 64-bit |
| force_type | input | 5 | Forced trap types; any set bit fires the trap |
| trap_fire | output | 1 | Trap decision |
| cond_bits | output | 5 | Raw relation bits in the R1 order |

## Verification
The hardest cases to reach from the ports are the ones where the two domains disagree, or where narrow mode has to hide a difference. Examples are the most-negative value against the most-positive value, and operand pairs that differ only above bit 31 while `narrow_mode` is 1. The bench reaches these with a curated set of corner values chosen for their sign bits at positions 31 and 63. It sweeps every ordered pair of these values in both modes, under several masks. Each case's expected relations are computed in the bench by explicit sign or zero extension.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;
    localparam int unsigned NCOND = 5;

    // Position of each relation in the condition vector
    typedef enum int unsigned {
        C_GTU = 0,
        C_LTU = 1,
        C_EQ  = 2,
        C_GTS = 3,
        C_LTS = 4
    } cond_idx_e;
endpackage

// File: rtl/trapcmp_operand.sv
module trapcmp_operand #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              narrow,
    output logic [DATA_W-1:0] sx,
    output logic [DATA_W-1:0] zx
);
    localparam int unsigned UP_W = DATA_W - HALF_W;

    always_comb begin
        if (narrow) begin
            sx = {{UP_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            zx = {{UP_W{1'b0}}, raw[HALF_W-1:0]};
        end else begin
            sx = raw;
            zx = raw;
        end
    end
endmodule

// File: rtl/trapcmp_relations.sv
module trapcmp_relations
    import trapcmp_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_sx,
    input  logic [DATA_W-1:0] b_sx,
    input  logic [DATA_W-1:0] a_zx,
    input  logic [DATA_W-1:0] b_zx,
    output logic [NCOND-1:0]  bits
);
    always_comb begin
        bits        = '0;
        bits[C_GTU] = a_zx > b_zx;
        bits[C_LTU] = a_zx < b_zx;
        bits[C_EQ]  = a_zx == b_zx;
        bits[C_GTS] = $signed(a_sx) > $signed(b_sx);
        bits[C_LTS] = $signed(a_sx) < $signed(b_sx);
    end
endmodule

// File: rtl/trapcmp_decide.sv
module trapcmp_decide #(
    parameter int unsigned NC     = 5,
    parameter int unsigned TYPE_W = 5
) (
    input  logic [NC-1:0]     bits,
    input  logic [NC-1:0]     mask,
    input  logic [TYPE_W-1:0] force_vec,
    output logic              fire
);
    always_comb begin
        fire = (|force_vec) | (|(bits & mask));
    end
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
    import trapcmp_pkg::*;
#(
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned HALF_W     = 32,
    parameter int unsigned TYPE_W     = 5,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       a_i,
    input  logic [63:0]       b_i,
    input  logic [4:0]        cond_mask,
    input  logic              narrow_mode,
    input  logic [4:0]        force_type,
    output logic              trap_fire,
    output logic [4:0]        cond_bits
);
    logic [DATA_W-1:0] a_sx, a_zx, b_sx, b_zx;
    logic [NCOND-1:0]  rel_c;
    logic              fire_c;

    trapcmp_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_opa (
        .raw(a_i), .narrow(narrow_mode), .sx(a_sx), .zx(a_zx)
    );

    trapcmp_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_opb (
        .raw(b_i), .narrow(narrow_mode), .sx(b_sx), .zx(b_zx)
    );

    trapcmp_relations #(.DATA_W(DATA_W)) u_rel (
        .a_sx(a_sx), .b_sx(b_sx), .a_zx(a_zx), .b_zx(b_zx), .bits(rel_c)
    );

    trapcmp_decide #(.NC(NCOND), .TYPE_W(TYPE_W)) u_dec (
        .bits(rel_c), .mask(cond_mask), .force_vec(force_type), .fire(fire_c)
    );

    generate
        if (REGISTERED) begin : g_reg
            logic             fire_q;
            logic [NCOND-1:0] rel_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fire_q <= 1'b0;
                    rel_q  <= '0;
                end else begin
                    fire_q <= fire_c;
                    rel_q  <= rel_c;
                end
            end

            always_comb begin
                trap_fire = fire_q;
                cond_bits = rel_q;
            end
        end else begin : g_comb
            always_comb begin
                trap_fire = fire_c;
                cond_bits = rel_c;
            end
        end
    endgenerate
endmodule

// File: rtl/trapcmp_unit_chk.sv
module trapcmp_unit_chk #(
    parameter int unsigned HALF_W     = 32,
    parameter bit          REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic [4:0]  cond_mask,
    input logic        narrow_mode,
    input logic [4:0]  force_type,
    input logic        trap_fire,
    input logic [4:0]  cond_bits
);
    // Inputs aligned to the cycle the outputs describe
    logic [63:0] sa, sb;
    logic [4:0]  smask, sforce;
    logic        snarrow, sok;

    generate
        if (REGISTERED) begin : g_shadow
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sa <= '0; sb <= '0; smask <= '0; sforce <= '0;
                    snarrow <= 1'b0; sok <= 1'b0;
                end else begin
                    sa <= a_i; sb <= b_i; smask <= cond_mask;
                    sforce <= force_type; snarrow <= narrow_mode; sok <= 1'b1;
                end
            end
        end else begin : g_direct
            always_comb begin
                sa = a_i; sb = b_i; smask = cond_mask;
                sforce = force_type; snarrow = narrow_mode; sok = 1'b1;
            end
        end
    endgenerate

    a_r8_unsigned_one: assert property (@(posedge clk) disable iff (!rst_n)
        sok |-> $onehot(cond_bits[2:0]));

    a_r8_signed_one: assert property (@(posedge clk) disable iff (!rst_n)
        sok |-> $onehot(cond_bits[4:2]));

    a_r2_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (sok && sforce != 5'd0) |-> trap_fire);

    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sok && smask == 5'd0 && sforce == 5'd0) |-> !trap_fire);

    a_r3_masked_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (sok && (cond_bits & smask) != 5'd0) |-> trap_fire);

    a_r6_narrow_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (sok && snarrow && sa[HALF_W-1:0] == sb[HALF_W-1:0]) |-> cond_bits[2]);

    a_r7_wide_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (sok && !snarrow) |-> (cond_bits[2] == (sa == sb)));
endmodule

bind trapcmp_unit trapcmp_unit_chk #(
    .HALF_W(HALF_W), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cond_mask(cond_mask),
    .narrow_mode(narrow_mode), .force_type(force_type),
    .trap_fire(trap_fire), .cond_bits(cond_bits)
);

// File: tb/tb_trapcmp_unit.sv
module tb_trapcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [4:0]  cond_mask = '0, force_type = '0;
    logic        narrow_mode = 1'b0;
    logic        fire_r, fire_c;
    logic [4:0]  bits_r, bits_c;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    trapcmp_unit #(.REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cond_mask(cond_mask),
        .narrow_mode(narrow_mode), .force_type(force_type),
        .trap_fire(fire_r), .cond_bits(bits_r)
    );

    trapcmp_unit #(.REGISTERED(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cond_mask(cond_mask),
        .narrow_mode(narrow_mode), .force_type(force_type),
        .trap_fire(fire_c), .cond_bits(bits_c)
    );

    function automatic logic [63:0] corner(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h0000_0000_0000_0001;
            2:  return 64'hFFFF_FFFF_FFFF_FFFF;
            3:  return 64'h7FFF_FFFF_FFFF_FFFF;
            4:  return 64'h8000_0000_0000_0000;
            5:  return 64'h0000_0000_8000_0000;
            6:  return 64'h0000_0000_7FFF_FFFF;
            7:  return 64'h1234_5678_0000_0005;
            8:  return 64'hABCD_0000_0000_0005;
            9:  return 64'hFFFF_FFFF_0000_0000;
            10: return 64'h0000_0001_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_8000_0001;
        endcase
    endfunction

    function automatic logic [4:0] expect_bits(input logic [63:0] a,
                                               input logic [63:0] b,
                                               input logic        nar);
        logic [63:0] sa, sb, ua, ub;
        logic [4:0]  r;
        if (nar) begin
            sa = {{32{a[31]}}, a[31:0]}; sb = {{32{b[31]}}, b[31:0]};
            ua = {32'd0, a[31:0]};       ub = {32'd0, b[31:0]};
        end else begin
            sa = a; sb = b; ua = a; ub = b;
        end
        r[0] = ua > ub;
        r[1] = ua < ub;
        r[2] = ua == ub;
        r[3] = $signed(sa) > $signed(sb);
        r[4] = $signed(sa) < $signed(sb);
        return r;
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b a=%h b=%h narrow=%0b mask=%b force=%b",
                     req, act, exp, a_i, b_i, narrow_mode, cond_mask, force_type);
        end
    endtask

    // Drive at falling edge, let one rising edge load, sample 2 ns later.
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic nar,
                         input logic [4:0] m, input logic [4:0] f);
        @(negedge clk);
        a_i = a; b_i = b; narrow_mode = nar; cond_mask = m; force_type = f;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [4:0] eb;
        logic       ef;
        // R9: reset state with busy inputs
        a_i = 64'd5; b_i = 64'd5; cond_mask = 5'b00100; force_type = 5'b00001;
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset", {fire_r, bits_r}, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R5 R6 R7 R3 R8 R10: all corner pairs, both modes, several masks
        for (int nar = 0; nar < 2; nar++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    for (int mk = 0; mk < 7; mk++) begin
                        logic [4:0] m;
                        m = (mk < 5) ? 5'(1 << mk) : ((mk == 5) ? 5'h1F : 5'h00);
                        eb = expect_bits(corner(i), corner(j), nar[0]);
                        ef = |(eb & m);
                        apply(corner(i), corner(j), nar[0], m, 5'd0);
                        if (mk == 0)
                            check(nar ? "R1 R5 R6 bits" : "R1 R7 bits",
                                  {1'b0, bits_r}, {1'b0, eb});
                        check(mk == 6 ? "R4 quiet" : "R3 fire",
                              {5'd0, fire_r}, {5'd0, ef});
                        if (mk == 5)
                            check("R10 comb match", {fire_c, bits_c}, {ef, eb});
                    end
                end
            end
        end

        // R8: explicit corner, most-negative vs most-positive in wide mode
        apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 5'd0, 5'd0);
        check("R8 R7 minneg vs maxpos", {1'b0, bits_r}, {1'b0, 5'b10001});

        // R6: differ only above bit 31 in narrow mode -> equal
        apply(64'h0000_0001_0000_0042, 64'hFFFF_0000_0000_0042, 1'b1, 5'b00100, 5'd0);
        check("R6 upper ignored", {fire_r, bits_r}, {1'b1, 5'b00100});

        // R2: every nonzero force vector with a zero mask and equal operands
        for (int f = 1; f < 32; f++) begin
            apply(64'd9, 64'd9, 1'b0, 5'd0, 5'(f));
            check("R2 forced", {5'd0, fire_r}, 6'd1);
        end

        // R9: one-cycle latency, old result still visible before the edge
        apply(64'd1, 64'd2, 1'b0, 5'd0, 5'd0);
        @(negedge clk);
        a_i = 64'd3; b_i = 64'd2;
        #1;
        check("R9 before edge", {1'b0, bits_r}, {1'b0, 5'b10010});
        check("R10 same cycle", {1'b0, bits_c}, {1'b0, 5'b01001});
        @(posedge clk);
        #2;
        check("R9 after edge", {1'b0, bits_r}, {1'b0, 5'b01001});

        finish_run();
    end
endmodule